// File: doc/BRIEF.md
# Auto-Increment Pointer Memory Port

This block puts a byte-addressed local RAM behind a small set of host registers, so a host that cannot map the RAM into its address space can still reach every location. The host loads a read pointer or a write pointer, then streams accesses through one data register. Each data access uses the matching pointer and then moves it forward by the width of the access: two for a 16-bit access and one for a byte access.

Because the step follows the access width, a transfer that begins or ends on an odd byte can use byte accesses at its edges and 16-bit accesses in between, all on the same stream. The read and write pointers are independent, so a read stream and a write stream can be interleaved without reloading either pointer. Words are little-endian, and both pointers wrap around the end of the RAM.

Top module: `ptr_mem_port`

## Requirements
- R1: After reset both pointers are zero, `host_rvalid` is low and `host_rdata` is zero.
- R2: A host write with `host_sel` = 2'b01 loads the read pointer, and one with `host_sel` = 2'b10 loads the write pointer, from `host_wdata` taken modulo the RAM size. A host read of either select returns that pointer, zero-extended. A read with `host_sel` = 2'b11 returns zero, and a write with that select changes nothing.
- R3: A 16-bit host read with `host_sel` = 2'b00 returns the byte at the read pointer in bits 7:0 and the next byte in bits 15:8, then adds 2 to the read pointer.
- R4: A byte host read (`host_wide` low) with `host_sel` = 2'b00 returns the byte at the read pointer in bits 7:0 with bits 15:8 zero, then adds 1 to the read pointer.
- R5: A 16-bit host write with `host_sel` = 2'b00 stores `host_wdata[7:0]` at the write pointer and `host_wdata[15:8]` at the next byte, then adds 2 to the write pointer.
- R6: A byte host write with `host_sel` = 2'b00 stores `host_wdata[7:0]` at the write pointer, leaves every other byte unchanged, then adds 1 to the write pointer.
- R7: Pointer arithmetic and the second byte of a 16-bit access wrap modulo the RAM size.
- R8: Data reads leave the write pointer unchanged, and data writes leave the read pointer unchanged.
- R9: A stream of 16-bit writes that covers the whole RAM, with the value starting at 1 and increasing by 3 per word, reads back exactly through a 16-bit read stream started at address 0.
- R10: Every host read gives a one-cycle `host_rvalid` pulse in the cycle after the request, with its data on `host_rdata`. Otherwise `host_rvalid` is low and `host_rdata` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access request this cycle |
| host_write | input | 1 | 1 = write access, 0 = read access |
| host_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| host_sel | input | 2 | Register select: 00 data, 01 read pointer, 10 write pointer, 11 unused |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, registered |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The bench targets a 16-bit write at the last byte of the RAM. If the second byte does not wrap, address 0 is never written, and a design without wrap-around would write out of range. It mixes byte accesses at odd pointers with word accesses. If the step is fixed at two, or the lanes are swapped, the following reads come from the wrong offsets. It also interleaves reads and writes with no pointer reload between them, which shows whether the two pointers are coupled. The full-size rising pattern exposes aliasing in the address decode. Pointer readback after a load of 16'hFFFF shows whether the pointer is masked.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'b00,
        SEL_RPTR = 2'b01,
        SEL_WPTR = 2'b10,
        SEL_NONE = 2'b11
    } sel_e;

    localparam int HOST_W = 16;
    localparam int NUM_PTR = 2;
    localparam int RD_IDX = 0;
    localparam int WR_IDX = 1;
endpackage

// File: rtl/pmp_ptr.sv
module pmp_ptr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              wide,
    output logic [ADDR_W-1:0] ptr
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ptr = load_val;
        end else if (step) begin
            st_d.ptr = st_q.ptr + (wide ? ADDR_W'(2) : ADDR_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;
endmodule

// File: rtl/pmp_byte_ram.sv
module pmp_byte_ram #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic              we_hi,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [15:0]       wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [15:0]       rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic [ADDR_W-1:0] waddr_nx;
    logic [ADDR_W-1:0] raddr_nx;

    assign waddr_nx = waddr + ADDR_W'(1);
    assign raddr_nx = raddr + ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata[7:0];
            if (we_hi) begin
                mem[waddr_nx] <= wdata[15:8];
            end
        end
    end

    assign rdata = {mem[raddr_nx], mem[raddr]};
endmodule

// File: rtl/ptr_mem_port.sv
module ptr_mem_port #(
    parameter int ADDR_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_valid,
    input  logic        host_write,
    input  logic        host_wide,
    input  logic [1:0]  host_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        host_rvalid
);
    import pmp_pkg::*;

    typedef struct packed {
        logic [HOST_W-1:0] rdata;
        logic              rvalid;
    } port_state_t;

    port_state_t st_d, st_q;

    sel_e              sel;
    logic [NUM_PTR-1:0] ld_vec;
    logic [NUM_PTR-1:0] step_vec;
    logic [ADDR_W-1:0]  ptr_vec [NUM_PTR];
    logic [ADDR_W-1:0]  rd_ptr_q;
    logic [ADDR_W-1:0]  wr_ptr_q;
    logic [15:0]        ram_rd;
    logic               data_rd;
    logic               data_wr;

    assign sel      = sel_e'(host_sel);
    assign data_rd  = host_valid && !host_write && (sel == SEL_DATA);
    assign data_wr  = host_valid &&  host_write && (sel == SEL_DATA);

    assign ld_vec[RD_IDX]   = host_valid && host_write && (sel == SEL_RPTR);
    assign ld_vec[WR_IDX]   = host_valid && host_write && (sel == SEL_WPTR);
    assign step_vec[RD_IDX] = data_rd;
    assign step_vec[WR_IDX] = data_wr;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
        pmp_ptr #(.ADDR_W(ADDR_W)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld_vec[g]),
            .load_val (host_wdata[ADDR_W-1:0]),
            .step     (step_vec[g]),
            .wide     (host_wide),
            .ptr      (ptr_vec[g])
        );
    end

    assign rd_ptr_q = ptr_vec[RD_IDX];
    assign wr_ptr_q = ptr_vec[WR_IDX];

    pmp_byte_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (data_wr),
        .we_hi (host_wide),
        .waddr (wr_ptr_q),
        .wdata (host_wdata),
        .raddr (rd_ptr_q),
        .rdata (ram_rd)
    );

    always_comb begin
        st_d = st_q;
        st_d.rvalid = 1'b0;
        if (host_valid && !host_write) begin
            st_d.rvalid = 1'b1;
            unique case (sel)
                SEL_DATA: st_d.rdata = host_wide ? ram_rd : {8'h00, ram_rd[7:0]};
                SEL_RPTR: st_d.rdata = HOST_W'(rd_ptr_q);
                SEL_WPTR: st_d.rdata = HOST_W'(wr_ptr_q);
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata  = st_q.rdata;
    assign host_rvalid = st_q.rvalid;
endmodule

// File: rtl/ptr_mem_port_chk.sv
module ptr_mem_port_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_valid,
    input logic              host_write,
    input logic              host_wide,
    input logic [1:0]        host_sel,
    input logic [15:0]       host_rdata,
    input logic              host_rvalid,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic [ADDR_W-1:0] wr_ptr
);
    p_rvalid_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_write) |=> host_rvalid);

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_valid && !host_write) |=> (!host_rvalid && $stable(host_rdata)));

    p_word_read_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_write && host_sel == 2'b00 && host_wide)
        |=> rd_ptr == ADDR_W'($past(rd_ptr) + ADDR_W'(2)));

    p_byte_write_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_write && host_sel == 2'b00 && !host_wide)
        |=> wr_ptr == ADDR_W'($past(wr_ptr) + ADDR_W'(1)));

    p_read_keeps_wptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_write) |=> $stable(wr_ptr));

    p_write_keeps_rptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_write && host_sel == 2'b00) |=> $stable(rd_ptr));
endmodule

bind ptr_mem_port ptr_mem_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_valid  (host_valid),
    .host_write  (host_write),
    .host_wide   (host_wide),
    .host_sel    (host_sel),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .rd_ptr      (rd_ptr_q),
    .wr_ptr      (wr_ptr_q)
);

// File: tb/ptr_mem_port_tb.sv
module ptr_mem_port_tb;
    localparam int ADDR_W = 10;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MASK   = DEPTH - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic        host_wide = 1'b0;
    logic [1:0]  host_sel = 2'b00;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] model [DEPTH];
    int m_rp = 0;
    int m_wp = 0;

    always #5 clk = ~clk;

    ptr_mem_port #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
        .host_wide(host_wide), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid)
    );

    function automatic logic [15:0] exp_word(int p);
        return {model[(p + 1) & MASK], model[p & MASK]};
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Drive one access at a negedge; outputs are sampled at the following negedge.
    task automatic op(logic wr, logic wide, logic [1:0] sel, logic [15:0] wd);
        host_valid = 1'b1; host_write = wr; host_wide = wide;
        host_sel = sel; host_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        host_valid = 1'b0;
        if (wr) begin
            if (sel == 2'b01) m_rp = int'(wd) & MASK;
            if (sel == 2'b10) m_wp = int'(wd) & MASK;
            if (sel == 2'b00) begin
                model[m_wp] = wd[7:0];
                if (wide) model[(m_wp + 1) & MASK] = wd[15:8];
                m_wp = (m_wp + (wide ? 2 : 1)) & MASK;
            end
        end
    endtask

    task automatic rd_check(string tag, logic wide, logic [1:0] sel);
        logic [15:0] exp;
        case (sel)
            2'b00: exp = wide ? exp_word(m_rp) : {8'h00, model[m_rp]};
            2'b01: exp = 16'(m_rp);
            2'b10: exp = 16'(m_wp);
            default: exp = 16'h0000;
        endcase
        op(1'b0, wide, sel, 16'h0);
        if (sel == 2'b00) m_rp = (m_rp + (wide ? 2 : 1)) & MASK;
        check(tag, host_rdata, exp);
        check({tag, " rvalid"}, {15'd0, host_rvalid}, 16'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] pat;
        logic [15:0] hold;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rvalid", {15'd0, host_rvalid}, 16'd0);
        check("R1 rdata", host_rdata, 16'd0);
        rd_check("R1 rptr", 1'b1, 2'b01);
        rd_check("R1 wptr", 1'b1, 2'b10);

        // R2: load masking and readback; unused select
        op(1'b1, 1'b1, 2'b01, 16'hFFFF);
        rd_check("R2 rptr mask", 1'b1, 2'b01);
        op(1'b1, 1'b1, 2'b10, 16'h1234);
        rd_check("R2 wptr mask", 1'b1, 2'b10);
        op(1'b1, 1'b1, 2'b11, 16'h0055);
        rd_check("R2 unused sel read", 1'b1, 2'b11);
        rd_check("R2 unused write left wptr", 1'b1, 2'b10);
        rd_check("R2 unused write left rptr", 1'b1, 2'b01);

        // R5 / R3 / R4: word write, word read, byte reads little-endian
        op(1'b1, 1'b1, 2'b10, 16'h0010);
        op(1'b1, 1'b1, 2'b00, 16'hA1B2);
        op(1'b1, 1'b1, 2'b00, 16'hC3D4);
        rd_check("R5 wptr after two words", 1'b1, 2'b10);
        op(1'b1, 1'b1, 2'b01, 16'h0010);
        rd_check("R3 word read", 1'b1, 2'b00);
        rd_check("R4 byte read even", 1'b0, 2'b00);
        rd_check("R4 byte read odd", 1'b0, 2'b00);
        rd_check("R4 rptr stepped", 1'b1, 2'b01);

        // R6: byte write at odd offset leaves neighbours alone
        op(1'b1, 1'b1, 2'b10, 16'h0011);
        op(1'b1, 1'b0, 2'b00, 16'hFF5A);
        op(1'b1, 1'b1, 2'b01, 16'h0010);
        rd_check("R6 odd byte write", 1'b1, 2'b00);
        rd_check("R6 neighbour kept", 1'b1, 2'b00);
        rd_check("R6 wptr +1", 1'b1, 2'b10);

        // R7: word write at the last byte wraps to address 0
        op(1'b1, 1'b1, 2'b10, 16'(MASK));
        op(1'b1, 1'b1, 2'b00, 16'hBEEF);
        rd_check("R7 wptr wrapped", 1'b1, 2'b10);
        op(1'b1, 1'b1, 2'b01, 16'(MASK));
        rd_check("R7 wrapped word read", 1'b1, 2'b00);
        rd_check("R7 rptr wrapped", 1'b1, 2'b01);

        // R8: interleaved streams without reloads
        op(1'b1, 1'b1, 2'b10, 16'h0100);
        op(1'b1, 1'b1, 2'b01, 16'h0010);
        op(1'b1, 1'b1, 2'b00, 16'h1111);
        rd_check("R8 read after write", 1'b1, 2'b00);
        op(1'b1, 1'b0, 2'b00, 16'h0022);
        rd_check("R8 read continues", 1'b1, 2'b00);
        rd_check("R8 wptr", 1'b1, 2'b10);
        rd_check("R8 rptr", 1'b1, 2'b01);

        // R10: no read -> rvalid low, rdata held
        hold = host_rdata;
        op(1'b1, 1'b1, 2'b10, 16'h0200);
        check("R10 rvalid low", {15'd0, host_rvalid}, 16'd0);
        check("R10 rdata held", host_rdata, hold);

        // R9: full-size rising word pattern
        op(1'b1, 1'b1, 2'b10, 16'h0000);
        pat = 16'd1;
        for (int i = 0; i < DEPTH / 2; i++) begin
            op(1'b1, 1'b1, 2'b00, pat);
            pat = pat + 16'd3;
        end
        op(1'b1, 1'b1, 2'b01, 16'h0000);
        pat = 16'd1;
        for (int i = 0; i < DEPTH / 2; i++) begin
            op(1'b0, 1'b1, 2'b00, 16'h0);
            m_rp = (m_rp + 2) & MASK;
            check("R9 pattern word", host_rdata, pat);
            pat = pat + 16'd3;
        end

        // Random mix (R3 R4 R5 R6 R8)
        for (int i = 0; i < 600; i++) begin
            int kind;
            kind = int'($urandom_range(0, 9));
            if (kind < 3) begin
                op(1'b1, 1'($urandom_range(0, 1)), 2'b00, 16'($urandom));
            end else if (kind < 6) begin
                rd_check("R3 R4 random data read", 1'($urandom_range(0, 1)), 2'b00);
            end else if (kind == 6) begin
                op(1'b1, 1'b1, 2'b01, 16'($urandom));
            end else if (kind == 7) begin
                op(1'b1, 1'b1, 2'b10, 16'($urandom));
            end else begin
                rd_check("R8 random ptr read", 1'b1, 2'($urandom_range(1, 2)));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule